// File: doc/BRIEF.md
# Outstanding Miss Table with Waiter Merge

This block tracks second-level cache misses that are waiting on the memory system. Each slot remembers the missing line address, the kind of request sent (shared read, exclusive read, or upgrade), the cache way set aside for the returning fill, and a short ordered list of first-level miss indices waiting for that line. A request is classified in the same cycle it is presented, and the caller gets both a raw outcome and the action it should take.

A new line whose set is idle takes the lowest free slot and is issued to memory. A request for a line that is already outstanding with a compatible kind joins that slot: a demand miss adds its first-level index to the list, and a prefetch is simply dropped. A clash on the set, or a request the slot cannot absorb, is refused. When the reply for a slot arrives, the block shows the reserved way and line for the fill. It then releases the waiting first-level indices one per cycle, and frees the slot with the last one.

Top module: `mht_table`

## Requirements
- R1: After reset every slot is free, `wake_valid_o` and `fill_valid_o` are 0, and both counters read 0.
- R2: A request whose set (line bits [SET_W-1:0]) matches no busy slot, with a slot free, gets result 0 (success) and the lowest free index. A demand request gets response 0 (issue), and `miss_cnt_o` increments at the next edge.
- R3: A request for the line of a busy, non-draining slot gets result 1 (merge) and that slot's index if the kinds are compatible. Kinds are compatible when the request is a shared read (cmd 0) or the slot holds an exclusive read (cmd 1) or an upgrade (cmd 2). A demand request also needs fewer than DEPTH waiters in the slot. It then gets response 1 (stall), its index is appended, and `miss_cnt_o` is unchanged.
- R4: Result 2 (conflict) is given when a busy slot has the same set but a different line, is draining, is incompatible, or already holds DEPTH waiters for a demand request. For a demand request the response is 2 (retry) and `retry_cnt_o` increments.
- R5: With every slot busy and no set match, the result is 3 (full). A demand request gets response 2 (retry) and `retry_cnt_o` increments.
- R6: A prefetch (`alloc_pf_i`=1) never touches `retry_cnt_o` or `miss_cnt_o`. On success it takes a slot with no waiters and gets response 0. On merge it gets response 4 and appends nothing. On conflict or full it gets response 3.
- R7: A reply to a busy, non-draining slot raises `fill_valid_o` in the same cycle, with that slot's reserved way and line address.
- R8: Starting the cycle after a reply, the slot's waiters appear on `wake_l1_o` one per cycle in the order they were appended, tagged with the slot index. A slot with no waiters emits nothing.
- R9: A slot is freed at the edge that ends the cycle of its last waiter, or at the edge after the reply if it has no waiters. A request made during that last cycle still sees the slot as busy.
- R10: A reply naming a free or already-draining slot is ignored: `fill_valid_o` stays 0 and nothing is emitted.
- R11: When several slots are draining, the lowest-indexed one emits first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Allocation request present |
| alloc_line_i | input | LINE_W | Line address of the request |
| alloc_cmd_i | input | 2 | 0 shared read, 1 exclusive read, 2 upgrade |
| alloc_pf_i | input | 1 | Request is a prefetch |
| alloc_way_i | input | WAY_W | Way reserved for the fill |
| alloc_l1_i | input | L1_W | First-level miss index of a demand request |
| alloc_result_o | output | 2 | 0 success, 1 merge, 2 conflict, 3 full |
| alloc_resp_o | output | 3 | 0 issue, 1 stall, 2 retry, 3 prefetch fail, 4 prefetch merge |
| alloc_idx_o | output | IDX_W | Slot taken or joined |
| reply_valid_i | input | 1 | Memory reply present |
| reply_idx_i | input | IDX_W | Slot the reply belongs to |
| fill_valid_o | output | 1 | Reply accepted this cycle |
| fill_way_o | output | WAY_W | Reserved way of the replied slot |
| fill_line_o | output | LINE_W | Line address of the replied slot |
| wake_valid_o | output | 1 | A waiter is released this cycle |
| wake_l1_o | output | L1_W | Released first-level miss index |
| wake_entry_o | output | IDX_W | Slot the waiter came from |
| miss_cnt_o | output | CNT_W | Demand requests issued to memory |
| retry_cnt_o | output | CNT_W | Demand requests told to retry |

## Verification
Requests are tried against five slot states: an idle set, the same line held shared, the same line held exclusive, the same set with another line, and a slot whose waiter list is full. This separates merge from each kind of conflict. The same address sequence is replayed as prefetches to show that only the response codes differ and that neither counter moves. Replies are given to a slot with four waiters, to two slots whose drains overlap, and to a prefetch slot with none. These show append order, lowest-first arbitration and the free timing. A request made in the free cycle, and a reply to a freed slot, fix the edge at which the slot returns.

// File: rtl/mht_pkg.sv
package mht_pkg;
  typedef enum logic [1:0] {CMD_GET = 2'd0, CMD_GETX = 2'd1, CMD_UPG = 2'd2} cmd_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_MERGE = 2'd1, RES_CONFLICT = 2'd2, RES_FULL = 2'd3} res_e;
  typedef enum logic [2:0] {
    RSP_ISSUE = 3'd0, RSP_STALL = 3'd1, RSP_RETRY = 3'd2, RSP_PF_FAIL = 3'd3, RSP_PF_MERGE = 3'd4
  } rsp_e;
endpackage

// File: rtl/mht_entry.sv
module mht_entry #(
  parameter int LINE_W = 12,
  parameter int WAY_W  = 2,
  parameter int L1_W   = 3,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              seed_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [1:0]        cmd_i,
  input  logic [WAY_W-1:0]  way_i,
  input  logic              push_i,
  input  logic [L1_W-1:0]   push_l1_i,
  input  logic              reply_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic              drain_o,
  output logic [LINE_W-1:0] line_o,
  output logic [1:0]        cmd_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [L1_W-1:0]   head_o
);
  logic              valid_q, drain_q, free;
  logic [LINE_W-1:0] line_q;
  logic [1:0]        cmd_q;
  logic [WAY_W-1:0]  way_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [L1_W-1:0]   wq_q [DEPTH];

  // release together with the last waiter
  assign free = drain_q && (cnt_q == '0 || (cnt_q == CNT_W'(1) && pop_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      drain_q <= 1'b0;
      line_q  <= '0;
      cmd_q   <= '0;
      way_q   <= '0;
      cnt_q   <= '0;
      for (int k = 0; k < DEPTH; k++) wq_q[k] <= '0;
    end else if (alloc_i) begin
      valid_q  <= 1'b1;
      drain_q  <= 1'b0;
      line_q   <= line_i;
      cmd_q    <= cmd_i;
      way_q    <= way_i;
      cnt_q    <= CNT_W'(seed_i);
      wq_q[0]  <= push_l1_i;
    end else if (valid_q) begin
      if (reply_i) drain_q <= 1'b1;
      if (push_i) begin
        for (int k = 0; k < DEPTH; k++)
          if (CNT_W'(k) == cnt_q) wq_q[k] <= push_l1_i;
        cnt_q <= cnt_q + 1'b1;
      end
      if (pop_i) begin
        for (int k = 0; k < DEPTH - 1; k++) wq_q[k] <= wq_q[k+1];
        cnt_q <= cnt_q - 1'b1;
      end
      if (free) begin
        valid_q <= 1'b0;
        drain_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign drain_o = drain_q;
  assign line_o  = line_q;
  assign cmd_o   = cmd_q;
  assign way_o   = way_q;
  assign cnt_o   = cnt_q;
  assign head_o  = wq_q[0];

  p_push_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> valid_q && !drain_q && (cnt_q < CNT_W'(DEPTH)));
  p_alloc_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q);
  p_pop_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> drain_q && (cnt_q != '0));
  p_free_late_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_q) |-> $past(drain_q) && ($past(cnt_q) <= CNT_W'(1)));
endmodule

// File: rtl/mht_alloc.sv
module mht_alloc
  import mht_pkg::*;
#(
  parameter int N      = 8,
  parameter int LINE_W = 12,
  parameter int SET_W  = 4,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = $clog2(N),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N-1:0]               valid_i,
  input  logic [N-1:0]               drain_i,
  input  logic [N-1:0][LINE_W-1:0]   line_i,
  input  logic [N-1:0][1:0]          cmd_i,
  input  logic [N-1:0][CNT_W-1:0]    cnt_i,
  input  logic [LINE_W-1:0]          req_line_i,
  input  logic [1:0]                 req_cmd_i,
  input  logic                       req_pf_i,
  output logic [1:0]                 result_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [IDX_W-1:0]           free_idx_o
);
  logic [N-1:0]     set_hit;
  logic             any_hit, any_free, compat, same_line, room;
  logic [IDX_W-1:0] hit_idx, free_idx;

  always_comb begin
    set_hit  = '0;
    any_hit  = 1'b0;
    any_free = 1'b0;
    hit_idx  = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid_i[i] && line_i[i][SET_W-1:0] == req_line_i[SET_W-1:0]) begin
        set_hit[i] = 1'b1;
        any_hit    = 1'b1;
        hit_idx    = IDX_W'(i);
      end
      if (!valid_i[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    compat    = (req_cmd_i == CMD_GET) || (cmd_i[hit_idx] != CMD_GET);
    same_line = line_i[hit_idx] == req_line_i;
    room      = req_pf_i || (cnt_i[hit_idx] < CNT_W'(DEPTH));
    if (any_hit) begin
      if (!drain_i[hit_idx] && same_line && compat && room) result_o = RES_MERGE;
      else result_o = RES_CONFLICT;
    end else if (any_free) result_o = RES_OK;
    else result_o = RES_FULL;
    idx_o = (result_o == RES_MERGE) ? hit_idx : free_idx;
  end

  assign free_idx_o = free_idx;

  p_one_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_hit));
  p_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o == RES_FULL) |-> (&valid_i));
endmodule

// File: rtl/mht_drain.sv
module mht_drain #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     drain_i,
  input  logic [N-1:0]     has_i,
  output logic [N-1:0]     pop_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] elig;
  assign elig = drain_i & has_i;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
    pop_o = '0;
    if (valid_o) pop_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/mht_table.sv
module mht_table
  import mht_pkg::*;
#(
  parameter int N      = 8,
  parameter int DEPTH  = 4,
  parameter int LINE_W = 12,
  parameter int SET_W  = 4,
  parameter int WAY_W  = 2,
  parameter int L1_W   = 3,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic [1:0]        alloc_cmd_i,
  input  logic              alloc_pf_i,
  input  logic [WAY_W-1:0]  alloc_way_i,
  input  logic [L1_W-1:0]   alloc_l1_i,
  output logic [1:0]        alloc_result_o,
  output logic [2:0]        alloc_resp_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              reply_valid_i,
  input  logic [IDX_W-1:0]  reply_idx_i,
  output logic              fill_valid_o,
  output logic [WAY_W-1:0]  fill_way_o,
  output logic [LINE_W-1:0] fill_line_o,
  output logic              wake_valid_o,
  output logic [L1_W-1:0]   wake_l1_o,
  output logic [IDX_W-1:0]  wake_entry_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  retry_cnt_o
);
  localparam int WC_W = $clog2(DEPTH + 1);

  logic [N-1:0]             ent_valid, ent_drain, ent_has, ent_pop;
  logic [N-1:0][LINE_W-1:0] ent_line;
  logic [N-1:0][1:0]        ent_cmd;
  logic [N-1:0][WAY_W-1:0]  ent_way;
  logic [N-1:0][WC_W-1:0]   ent_cnt;
  logic [N-1:0][L1_W-1:0]   ent_head;
  logic [IDX_W-1:0]         free_idx, drain_idx;
  logic                     take, join_q, reply_ok, bad;
  logic [CNT_W-1:0]         miss_q, retry_q;

  mht_alloc #(.N(N), .LINE_W(LINE_W), .SET_W(SET_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(WC_W)) u_alloc (
    .clk_i, .rst_ni,
    .valid_i(ent_valid), .drain_i(ent_drain), .line_i(ent_line), .cmd_i(ent_cmd), .cnt_i(ent_cnt),
    .req_line_i(alloc_line_i), .req_cmd_i(alloc_cmd_i), .req_pf_i(alloc_pf_i),
    .result_o(alloc_result_o), .idx_o(alloc_idx_o), .free_idx_o(free_idx)
  );

  assign take     = alloc_valid_i && (alloc_result_o == RES_OK);
  assign join_q   = alloc_valid_i && !alloc_pf_i && (alloc_result_o == RES_MERGE);
  assign bad      = (alloc_result_o == RES_CONFLICT) || (alloc_result_o == RES_FULL);
  assign reply_ok = reply_valid_i && ent_valid[reply_idx_i] && !ent_drain[reply_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign ent_has[g] = ent_cnt[g] != '0;
    mht_entry #(.LINE_W(LINE_W), .WAY_W(WAY_W), .L1_W(L1_W), .DEPTH(DEPTH), .CNT_W(WC_W)) u_ent (
      .clk_i, .rst_ni,
      .alloc_i  (take && free_idx == IDX_W'(g)),
      .seed_i   (!alloc_pf_i),
      .line_i   (alloc_line_i),
      .cmd_i    (alloc_cmd_i),
      .way_i    (alloc_way_i),
      .push_i   (join_q && alloc_idx_o == IDX_W'(g)),
      .push_l1_i(alloc_l1_i),
      .reply_i  (reply_ok && reply_idx_i == IDX_W'(g)),
      .pop_i    (ent_pop[g]),
      .valid_o  (ent_valid[g]),
      .drain_o  (ent_drain[g]),
      .line_o   (ent_line[g]),
      .cmd_o    (ent_cmd[g]),
      .way_o    (ent_way[g]),
      .cnt_o    (ent_cnt[g]),
      .head_o   (ent_head[g])
    );
  end

  mht_drain #(.N(N), .IDX_W(IDX_W)) u_drain (
    .drain_i(ent_drain), .has_i(ent_has), .pop_o(ent_pop), .valid_o(wake_valid_o), .idx_o(drain_idx)
  );

  assign wake_entry_o = drain_idx;
  assign wake_l1_o    = ent_head[drain_idx];
  assign fill_valid_o = reply_ok;
  assign fill_way_o   = ent_way[reply_idx_i];
  assign fill_line_o  = ent_line[reply_idx_i];

  always_comb begin
    unique case (alloc_result_o)
      RES_OK:    alloc_resp_o = RSP_ISSUE;
      RES_MERGE: alloc_resp_o = alloc_pf_i ? RSP_PF_MERGE : RSP_STALL;
      default:   alloc_resp_o = alloc_pf_i ? RSP_PF_FAIL : RSP_RETRY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q  <= '0;
      retry_q <= '0;
    end else if (alloc_valid_i && !alloc_pf_i) begin
      if (alloc_result_o == RES_OK) miss_q <= miss_q + 1'b1;
      if (bad) retry_q <= retry_q + 1'b1;
    end
  end

  assign miss_cnt_o  = miss_q;
  assign retry_cnt_o = retry_q;

  p_merge_no_issue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_result_o == RES_MERGE) |=> $stable(miss_cnt_o));
  p_pf_no_retry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_pf_i) |=> $stable(retry_cnt_o) && $stable(miss_cnt_o));
  p_fill_drains_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> ent_drain[$past(reply_idx_i)]);
  p_wake_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_valid_o |-> ent_drain[wake_entry_o]);
endmodule

// File: tb/tb_mht_table.sv
module tb_mht_table;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_valid_i = 1'b0;
  logic [11:0] alloc_line_i = '0;
  logic [1:0]  alloc_cmd_i = '0;
  logic        alloc_pf_i = 1'b0;
  logic [1:0]  alloc_way_i = '0;
  logic [2:0]  alloc_l1_i = '0;
  logic [1:0]  alloc_result_o;
  logic [2:0]  alloc_resp_o;
  logic [2:0]  alloc_idx_o;
  logic        reply_valid_i = 1'b0;
  logic [2:0]  reply_idx_i = '0;
  logic        fill_valid_o;
  logic [1:0]  fill_way_o;
  logic [11:0] fill_line_o;
  logic        wake_valid_o;
  logic [2:0]  wake_l1_o;
  logic [2:0]  wake_entry_o;
  logic [15:0] miss_cnt_o, retry_cnt_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  mht_table dut (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic do_alloc(int line, int cmd, bit pf, int way, int l1,
                          int e_res, int e_rsp, int e_idx, int d_miss, int d_retry, string tag);
    int m0, r0;
    alloc_line_i = 12'(line); alloc_cmd_i = 2'(cmd); alloc_pf_i = pf;
    alloc_way_i = 2'(way); alloc_l1_i = 3'(l1); alloc_valid_i = 1'b1;
    #1;
    m0 = miss_cnt_o; r0 = retry_cnt_o;
    chk({tag, " result"}, alloc_result_o, e_res);
    chk({tag, " resp"}, alloc_resp_o, e_rsp);
    if (e_res < 2) chk({tag, " idx"}, alloc_idx_o, e_idx);
    @(negedge clk_i);
    alloc_valid_i = 1'b0;
    chk({tag, " miss count"}, miss_cnt_o, m0 + d_miss);
    chk({tag, " retry count"}, retry_cnt_o, r0 + d_retry);
  endtask

  task automatic chk_wake(bit v, int ent, int l1, string tag);
    chk({tag, " wake valid"}, wake_valid_o, v);
    if (v) begin
      chk({tag, " wake entry"}, wake_entry_o, ent);
      chk({tag, " wake l1"}, wake_l1_o, l1);
    end
  endtask

  task automatic chk_fill(bit v, int way, int line, string tag);
    chk({tag, " fill valid"}, fill_valid_o, v);
    if (v) begin
      chk({tag, " fill way"}, fill_way_o, way);
      chk({tag, " fill line"}, fill_line_o, line);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk("R1 wake", wake_valid_o, 0);
    chk("R1 fill", fill_valid_o, 0);
    chk("R1 miss", miss_cnt_o, 0);
    chk("R1 retry", retry_cnt_o, 0);
    @(negedge clk_i);
  endtask

  task automatic t_basic;
    do_alloc(12'h010, 0, 0, 1, 3, 0, 0, 0, 1, 0, "R1 R2 first alloc");
    do_alloc(12'h010, 0, 0, 1, 5, 1, 1, 0, 0, 0, "R3 shared merge");
    do_alloc(12'h010, 1, 0, 1, 2, 2, 2, 0, 0, 1, "R4 exclusive onto shared");
    do_alloc(12'h020, 0, 0, 0, 2, 2, 2, 0, 0, 1, "R4 same set other line");
    do_alloc(12'h010, 0, 0, 1, 6, 1, 1, 0, 0, 0, "R3 merge third");
    do_alloc(12'h010, 0, 0, 1, 7, 1, 1, 0, 0, 0, "R3 merge fourth");
    do_alloc(12'h010, 0, 0, 1, 1, 2, 2, 0, 0, 1, "R4 waiter list full");
    do_alloc(12'h031, 1, 0, 2, 2, 0, 0, 1, 1, 0, "R2 second slot");
    do_alloc(12'h031, 0, 0, 2, 4, 1, 1, 1, 0, 0, "R3 shared onto exclusive");
  endtask

  task automatic t_prefetch;
    do_alloc(12'h042, 0, 1, 3, 0, 0, 0, 2, 0, 0, "R6 prefetch issue");
    do_alloc(12'h042, 0, 1, 3, 0, 1, 4, 2, 0, 0, "R6 prefetch merge");
    do_alloc(12'h052, 0, 1, 3, 0, 2, 3, 0, 0, 0, "R6 prefetch conflict");
  endtask

  task automatic t_full;
    for (int i = 3; i < 8; i++)
      do_alloc(i, 0, 0, 0, 0, 0, 0, i, 1, 0, "R2 fill table");
    do_alloc(12'h003, 0, 0, 0, 6, 1, 1, 3, 0, 0, "R3 merge slot3");
    do_alloc(12'h008, 0, 0, 0, 0, 3, 2, 0, 0, 1, "R5 demand full");
    do_alloc(12'h009, 0, 1, 0, 0, 3, 3, 0, 0, 0, "R6 prefetch full");
  endtask

  task automatic t_drain_one;
    int exp_l1 [4] = '{3, 5, 6, 7};
    reply_valid_i = 1'b1; reply_idx_i = 3'd0;
    #1;
    chk_fill(1, 1, 12'h010, "R7 reply slot0");
    chk_wake(0, 0, 0, "R8 no wake in reply cycle");
    @(negedge clk_i);
    for (int c = 0; c < 4; c++) begin
      if (c == 0) begin
        reply_valid_i = 1'b1;
        alloc_valid_i = 1'b1; alloc_line_i = 12'h010; alloc_cmd_i = 2'd0; alloc_pf_i = 1'b0;
      end else if (c == 3) begin
        alloc_valid_i = 1'b1; alloc_line_i = 12'h00B;
      end else begin
        reply_valid_i = 1'b0;
        alloc_valid_i = 1'b0;
      end
      #1;
      chk_wake(1, 0, exp_l1[c], "R8 drain order");
      if (c == 0) begin
        chk_fill(0, 0, 0, "R10 reply to draining");
        chk("R4 draining slot result", alloc_result_o, 2);
      end
      if (c == 3) chk("R9 busy in free cycle", alloc_result_o, 3);
      @(negedge clk_i);
      reply_valid_i = 1'b0;
      alloc_valid_i = 1'b0;
    end
    #1;
    chk_wake(0, 0, 0, "R9 drained");
    #1;
    do_alloc(12'h00B, 0, 0, 1, 1, 0, 0, 0, 1, 0, "R9 freed slot reused");
  endtask

  task automatic t_priority;
    reply_valid_i = 1'b1; reply_idx_i = 3'd3;
    #1;
    chk_fill(1, 0, 12'h003, "R7 reply slot3");
    @(negedge clk_i);
    reply_idx_i = 3'd1;
    #1;
    chk_fill(1, 2, 12'h031, "R7 reply slot1");
    chk_wake(1, 3, 0, "R8 slot3 first waiter");
    @(negedge clk_i);
    reply_valid_i = 1'b0;
    #1;
    chk_wake(1, 1, 2, "R11 lower slot wins");
    @(negedge clk_i); #1;
    chk_wake(1, 1, 4, "R11 lower slot continues");
    @(negedge clk_i); #1;
    chk_wake(1, 3, 6, "R11 higher slot resumes");
    @(negedge clk_i);
    reply_valid_i = 1'b1; reply_idx_i = 3'd3;
    #1;
    chk_fill(0, 0, 0, "R10 reply to freed slot");
    chk_wake(0, 0, 0, "R10 nothing emitted");
    @(negedge clk_i);
    reply_valid_i = 1'b0;
    #1;
    chk_wake(0, 0, 0, "R10 still idle");
    @(negedge clk_i);
  endtask

  task automatic t_pf_reply;
    reply_valid_i = 1'b1; reply_idx_i = 3'd2;
    #1;
    chk_fill(1, 3, 12'h042, "R7 prefetch slot reply");
    @(negedge clk_i);
    reply_valid_i = 1'b0;
    #1;
    chk_wake(0, 0, 0, "R8 no waiters on prefetch slot");
    do_alloc(12'h052, 0, 0, 0, 5, 2, 2, 0, 0, 1, "R9 prefetch slot busy while freeing");
    do_alloc(12'h052, 0, 0, 0, 5, 0, 0, 1, 1, 0, "R2 lowest free index");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_prefetch();
    t_full();
    t_drain_one();
    t_priority();
    t_pf_reply();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule